// File: doc/BRIEF.md
# Physical Memory Type Resolver

The resolver answers one question for a memory subsystem: which cache memory type applies to a physical address range. Software-visible configuration lives in four kinds of register:
- a control word holding the default type and two enable bits;
- a table of 88 one-byte fixed-region types that covers the first megabyte;
- a parameterised number of variable regions, each a base/mask pair;
- an optional upper-memory limit that marks a write-back window above 4 GiB.

A requester hands over an inclusive start and end address with a valid/ready handshake. The block then walks the variable regions one per cycle and folds overlapping matches together with a fixed precedence rule. It pulses a done strobe with the 8-bit resolved type. One request is in flight at a time. The latency is always the same, whichever path decides the answer.

Special codes separate the cases that are not a memory type. 0xFF means the resolver is switched off. 0xFE means the range straddles a variable region boundary. Within a request, the first terminating condition met in region index order decides the result.

Top module: `memtype_resolver`

## Requirements
- R1: After synchronous reset `req_ready` is 1, `rsp_done` is 0 and every configuration register is zero, so a lookup returns 0xFF.
- R2: A write with `cfg_we`=1 stores `cfg_wdata` into the register chosen by `cfg_kind`, indexed by `cfg_idx` where needed. The kinds are 0=control, 1=fixed entry (byte in data[7:0]), 2=region base, 3=region mask and 4=upper limit. In the control word, bits [7:0] are the default type, bit 10 enables the fixed table and bit 11 enables the variable regions.
- R3: When both enable bits are clear the result is 0xFF.
- R4: When the fixed table is enabled and start < 0x100000, the result is the fixed entry chosen by start alone. 0x00000-0x7FFFF selects entry start[18:16]. 0x80000-0xBFFFF selects entry 8+start[17:14]. 0xC0000-0xFFFFF selects entry 24+start[17:12].
- R5: When R4 does not apply and the variable enable is clear, the result is the default type.
- R6: A region takes part only when bit 11 of its mask is set. Its type is base[7:0]. Bits [11:0] of base and mask play no part in matching.
- R7: An address matches a region when (addr & mask) == (base & mask). If start and end differ in matching, the result is 0xFE.
- R8: Type encodings are UC=0, WC=1, WT=4, WP=5 and WB=6. Among matching regions, equal types keep that type, UC with anything gives UC, WB with WT gives WT, and any other disagreement gives UC.
- R9: With variable regions enabled and no region matching, the result is the default type.
- R10: The upper limit register has bits [22:0] forced to zero on write. A request with start >= 0x1_0000_0000 and end below that limit resolves to WB, unless a terminating code (R7, R8 UC conflict) was met first.
- R11: `req_ready` is low from the accept edge until the result is delivered. `rsp_done` is a one-cycle pulse exactly NUM_VAR+1 cycles after the accept edge.
- R12: Regions are visited in increasing index order, and the first terminating event (0xFE or a UC conflict) fixes the result regardless of later regions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_kind | input | 3 | Register kind selector |
| cfg_idx | input | 7 | Fixed entry or region index |
| cfg_wdata | input | ADDR_W | Write data |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Resolver can accept a request |
| req_start | input | ADDR_W | Inclusive start address |
| req_end | input | ADDR_W | Inclusive end address |
| rsp_done | output | 1 | Result valid pulse |
| rsp_type | output | 8 | Resolved memory type or special code |

## Verification
The hardest situation to reach is an ordering conflict inside one request. A UC conflict between two early regions must win over a boundary straddle in a later region. A straddle in a later region must override an earlier clean match. The stimulus builds overlapping regions of different sizes, with a small region placed after a pair of clashing large ones. It then issues lookups whose end address sits inside one region and outside another, so that both orders of terminating events occur. The upper-limit window is probed with end addresses one byte on either side of the rounded limit, which shows that the forced-zero low bits take effect.

// File: rtl/memtype_pkg.sv
// Shared encodings for the memory type resolver.
// Assumes: type codes are 8 bits wide; the fixed table always covers the first 1 MiB.
package memtype_pkg;
    localparam logic [7:0] MT_UC      = 8'h00;
    localparam logic [7:0] MT_WC      = 8'h01;
    localparam logic [7:0] MT_WT      = 8'h04;
    localparam logic [7:0] MT_WP      = 8'h05;
    localparam logic [7:0] MT_WB      = 8'h06;
    localparam logic [7:0] MT_PARTIAL = 8'hFE;
    localparam logic [7:0] MT_OFF     = 8'hFF;

    localparam int FIXED_ENTRIES = 88;
    localparam int CFG_IDX_W     = 7;

    typedef enum logic [2:0] {
        CFG_CTRL   = 3'd0,
        CFG_FIXED  = 3'd1,
        CFG_VBASE  = 3'd2,
        CFG_VMASK  = 3'd3,
        CFG_UPLIM  = 3'd4
    } cfg_kind_e;

    typedef enum logic [1:0] {
        SC_IDLE = 2'd0,
        SC_WALK = 2'd1,
        SC_FIN  = 2'd2
    } scan_state_e;
endpackage

// File: rtl/memtype_cfg_regs.sv
// Configuration storage: control word, fixed-region table, variable base/mask
// pairs and the upper-memory limit. Written through a single write port.
// Assumes: indexes outside the implemented range are dropped.
module memtype_cfg_regs
    import memtype_pkg::*;
#(
    parameter int ADDR_W     = 40,
    parameter int NUM_VAR    = 8,
    parameter bit HAS_UPLIM  = 1'b1
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                cfg_we,
    input  logic [2:0]                          cfg_kind,
    input  logic [CFG_IDX_W-1:0]                cfg_idx,
    input  logic [ADDR_W-1:0]                   cfg_wdata,
    output logic [7:0]                          dflt_type,
    output logic                                fix_en,
    output logic                                var_en,
    output logic [FIXED_ENTRIES-1:0][7:0]       fixed_tbl,
    output logic [NUM_VAR-1:0][ADDR_W-1:0]      var_base,
    output logic [NUM_VAR-1:0][ADDR_W-1:0]      var_mask,
    output logic [ADDR_W-1:0]                   uplim
);
    localparam logic [ADDR_W-1:0] UPLIM_KEEP = {{(ADDR_W-23){1'b1}}, 23'd0};

    // Control word: default type and the two enables.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dflt_type <= '0;
            fix_en    <= 1'b0;
            var_en    <= 1'b0;
        end else if (cfg_we && cfg_kind == CFG_CTRL) begin
            dflt_type <= cfg_wdata[7:0];
            fix_en    <= cfg_wdata[10];
            var_en    <= cfg_wdata[11];
        end
    end

    genvar gi;
    generate
        for (gi = 0; gi < FIXED_ENTRIES; gi++) begin : g_fixed
            // One fixed-region type byte.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    fixed_tbl[gi] <= '0;
                else if (cfg_we && cfg_kind == CFG_FIXED && cfg_idx == CFG_IDX_W'(gi))
                    fixed_tbl[gi] <= cfg_wdata[7:0];
            end
        end

        for (gi = 0; gi < NUM_VAR; gi++) begin : g_var
            // One variable region base/mask pair.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    var_base[gi] <= '0;
                    var_mask[gi] <= '0;
                end else if (cfg_we && cfg_idx == CFG_IDX_W'(gi)) begin
                    if (cfg_kind == CFG_VBASE) var_base[gi] <= cfg_wdata;
                    if (cfg_kind == CFG_VMASK) var_mask[gi] <= cfg_wdata;
                end
            end
        end

        if (HAS_UPLIM) begin : g_uplim
            // Upper-memory limit, rounded down to an 8 MiB boundary on write.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    uplim <= '0;
                else if (cfg_we && cfg_kind == CFG_UPLIM)
                    uplim <= cfg_wdata & UPLIM_KEEP;
            end

            // R10: a limit write keeps the upper bits and clears the low 23.
            assert_uplim_round_R10: assert property (@(posedge clk) disable iff (!rst_n)
                (cfg_we && cfg_kind == CFG_UPLIM) |=>
                    (uplim[22:0] == 23'd0 && uplim[ADDR_W-1:23] == $past(cfg_wdata[ADDR_W-1:23])));
        end else begin : g_no_uplim
            assign uplim = '0;
        end
    endgenerate
endmodule

// File: rtl/memtype_fixed_lookup.sv
// Fixed-region lookup: turns the start address into a table index over the three
// granularities below 1 MiB and returns that entry.
// Assumes: only the start address matters; hit reports start < 1 MiB.
module memtype_fixed_lookup
    import memtype_pkg::*;
#(
    parameter int ADDR_W = 40
) (
    input  logic [ADDR_W-1:0]              addr,
    input  logic [FIXED_ENTRIES-1:0][7:0]  fixed_tbl,
    output logic                           hit,
    output logic [7:0]                     fixed_type
);
    localparam int IXW = $clog2(FIXED_ENTRIES);
    logic [IXW-1:0] ix;

    // Select the granularity from the top address bits below 1 MiB.
    always_comb begin
        hit = (addr[ADDR_W-1:20] == '0);
        if (!addr[19])
            ix = IXW'(addr[18:16]);
        else if (!addr[18])
            ix = IXW'(8) + IXW'(addr[17:14]);
        else
            ix = IXW'(24) + IXW'(addr[17:12]);
        fixed_type = fixed_tbl[ix];
    end
endmodule

// File: rtl/memtype_var_scan.sv
// Variable-region walker: latches a request, visits one region per cycle in
// index order and folds matches with the precedence rule. The first terminating
// event (straddle or UC conflict) is frozen for the rest of the walk.
// Assumes: configuration is stable while a walk is in progress.
module memtype_var_scan
    import memtype_pkg::*;
#(
    parameter int ADDR_W  = 40,
    parameter int NUM_VAR = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           accept,
    input  logic [ADDR_W-1:0]              req_start,
    input  logic [ADDR_W-1:0]              req_end,
    input  logic [NUM_VAR-1:0][ADDR_W-1:0] var_base,
    input  logic [NUM_VAR-1:0][ADDR_W-1:0] var_mask,
    output logic                           idle,
    output logic                           fin,
    output logic [ADDR_W-1:0]              start_q,
    output logic [ADDR_W-1:0]              end_q,
    output logic                           matched,
    output logic [7:0]                     acc_type,
    output logic                           term,
    output logic [7:0]                     term_type
);
    localparam int IW = (NUM_VAR > 1) ? $clog2(NUM_VAR) : 1;
    localparam logic [IW-1:0] LAST = IW'(NUM_VAR - 1);
    localparam logic [ADDR_W-1:0] MATCH_KEEP = {{(ADDR_W-12){1'b1}}, 12'd0};

    scan_state_e    state;
    logic [IW-1:0]  idx;
    logic [ADDR_W-1:0] cur_mask;
    logic [7:0]     cur_type;
    logic           cur_valid, s_hit, e_hit;
    logic           n_matched, n_term;
    logic [7:0]     n_acc, n_term_type;

    assign idle = (state == SC_IDLE);
    assign fin  = (state == SC_FIN);

    // Evaluate the region under the cursor against the latched range.
    always_comb begin
        cur_mask  = var_mask[idx] & MATCH_KEEP;
        cur_type  = var_base[idx][7:0];
        cur_valid = var_mask[idx][11];
        s_hit     = (((start_q ^ var_base[idx]) & cur_mask) == '0);
        e_hit     = (((end_q   ^ var_base[idx]) & cur_mask) == '0);
        n_matched   = matched;
        n_acc       = acc_type;
        n_term      = term;
        n_term_type = term_type;
        if (cur_valid && !term) begin
            if (s_hit != e_hit) begin
                n_term      = 1'b1;
                n_term_type = MT_PARTIAL;
            end else if (s_hit) begin
                if (!matched) begin
                    n_matched = 1'b1;
                    n_acc     = cur_type;
                end else if (acc_type == MT_UC || cur_type == MT_UC) begin
                    n_term      = 1'b1;
                    n_term_type = MT_UC;
                end else if ((acc_type == MT_WB && cur_type == MT_WT) ||
                             (acc_type == MT_WT && cur_type == MT_WB)) begin
                    n_acc = MT_WT;
                end else if (acc_type != cur_type) begin
                    n_term      = 1'b1;
                    n_term_type = MT_UC;
                end
            end
        end
    end

    // Sequencer: idle -> walk all regions -> one finish cycle -> idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SC_IDLE;
            idx   <= '0;
        end else begin
            case (state)
                SC_IDLE: if (accept) begin
                    state <= SC_WALK;
                    idx   <= '0;
                end
                SC_WALK: begin
                    if (idx == LAST) state <= SC_FIN;
                    else             idx   <= idx + 1'b1;
                end
                default: state <= SC_IDLE;
            endcase
        end
    end

    // Request latch and fold accumulators.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q   <= '0;
            end_q     <= '0;
            matched   <= 1'b0;
            acc_type  <= '0;
            term      <= 1'b0;
            term_type <= '0;
        end else if (state == SC_IDLE && accept) begin
            start_q   <= req_start;
            end_q     <= req_end;
            matched   <= 1'b0;
            acc_type  <= '0;
            term      <= 1'b0;
            term_type <= '0;
        end else if (state == SC_WALK) begin
            matched   <= n_matched;
            acc_type  <= n_acc;
            term      <= n_term;
            term_type <= n_term_type;
        end
    end

    // R12: once a terminating event is recorded it survives the rest of the walk.
    assert_term_frozen_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SC_WALK && term) |=> (term && $stable(term_type)));

    // R8: a terminating code is only ever UC or the straddle code.
    assert_term_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
        term |-> (term_type == MT_UC || term_type == MT_PARTIAL));
endmodule

// File: rtl/memtype_resolver.sv
// Physical memory type resolver top: configuration registers, fixed-region
// lookup, variable-region walker and final selection with the upper window.
// Assumes: one request at a time; configuration is not rewritten mid-lookup.
// Requires ADDR_W > 32 so that the 4 GiB boundary is representable.
module memtype_resolver
    import memtype_pkg::*;
#(
    parameter int ADDR_W    = 40,
    parameter int NUM_VAR   = 8,
    parameter bit HAS_FIXED = 1'b1,
    parameter bit HAS_UPLIM = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [2:0]           cfg_kind,
    input  logic [6:0]           cfg_idx,
    input  logic [ADDR_W-1:0]    cfg_wdata,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic [ADDR_W-1:0]    req_start,
    input  logic [ADDR_W-1:0]    req_end,
    output logic                 rsp_done,
    output logic [7:0]           rsp_type
);
    localparam logic [ADDR_W-1:0] FOUR_GIB = ADDR_W'(64'h1_0000_0000);
    localparam int LAT_W = 16;

    logic [7:0]                      dflt_type;
    logic                            fix_en, var_en;
    logic [FIXED_ENTRIES-1:0][7:0]   fixed_tbl;
    logic [NUM_VAR-1:0][ADDR_W-1:0]  var_base, var_mask;
    logic [ADDR_W-1:0]               uplim;
    logic                            sc_idle, sc_fin, matched, term;
    logic [ADDR_W-1:0]               start_q, end_q;
    logic [7:0]                      acc_type, term_type, fixed_type, result;
    logic                            fixed_hit, accept;

    assign req_ready = sc_idle;
    assign accept    = req_valid && sc_idle;

    memtype_cfg_regs #(.ADDR_W(ADDR_W), .NUM_VAR(NUM_VAR), .HAS_UPLIM(HAS_UPLIM)) u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_kind(cfg_kind),
        .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .dflt_type(dflt_type),
        .fix_en(fix_en), .var_en(var_en), .fixed_tbl(fixed_tbl),
        .var_base(var_base), .var_mask(var_mask), .uplim(uplim)
    );

    memtype_fixed_lookup #(.ADDR_W(ADDR_W)) u_fix (
        .addr(start_q), .fixed_tbl(fixed_tbl), .hit(fixed_hit), .fixed_type(fixed_type)
    );

    memtype_var_scan #(.ADDR_W(ADDR_W), .NUM_VAR(NUM_VAR)) u_scan (
        .clk(clk), .rst_n(rst_n), .accept(accept), .req_start(req_start),
        .req_end(req_end), .var_base(var_base), .var_mask(var_mask),
        .idle(sc_idle), .fin(sc_fin), .start_q(start_q), .end_q(end_q),
        .matched(matched), .acc_type(acc_type), .term(term), .term_type(term_type)
    );

    // Final selection in precedence order.
    always_comb begin
        if (!fix_en && !var_en)
            result = MT_OFF;
        else if (HAS_FIXED && fix_en && fixed_hit)
            result = fixed_type;
        else if (!var_en)
            result = dflt_type;
        else if (term)
            result = term_type;
        else if (HAS_UPLIM && start_q >= FOUR_GIB && end_q < uplim)
            result = MT_WB;
        else if (matched)
            result = acc_type;
        else
            result = dflt_type;
    end

    // Response register: one done pulse per finished walk.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_done <= 1'b0;
            rsp_type <= '0;
        end else begin
            rsp_done <= sc_fin;
            if (sc_fin) rsp_type <= result;
        end
    end

    // Checker counter: cycles since the last accept edge (saturating).
    logic [LAT_W-1:0] lat_cnt;
    always_ff @(posedge clk) begin
        if (!rst_n)
            lat_cnt <= '1;
        else if (accept)
            lat_cnt <= '0;
        else if (lat_cnt != '1)
            lat_cnt <= lat_cnt + 1'b1;
    end

    // R11: the result appears exactly NUM_VAR+1 cycles after acceptance.
    assert_latency_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> (lat_cnt == LAT_W'(NUM_VAR + 1)));

    // R11: done is a single-cycle pulse.
    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

    // R11: ready drops after an accepted request.
    assert_ready_drop_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R3: with both enables clear the off code is delivered.
    assert_off_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_done && !$past(fix_en) && !$past(var_en)) |-> (rsp_type == MT_OFF));
endmodule

// File: tb/sim_memtype_resolver.sv
// Scoreboard bench: the driver queues expected results, the monitor compares them
// with each done pulse and checks the handshake latency.
module sim_memtype_resolver;
    localparam int ADDR_W  = 40;
    localparam int NUM_VAR = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_we = 1'b0;
    logic [2:0]        cfg_kind = '0;
    logic [6:0]        cfg_idx = '0;
    logic [ADDR_W-1:0] cfg_wdata = '0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [ADDR_W-1:0] req_start = '0;
    logic [ADDR_W-1:0] req_end = '0;
    logic              rsp_done;
    logic [7:0]        rsp_type;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit finished = 1'b0;

    logic [7:0] exp_q[$];
    string      tag_q[$];
    int         acc_q[$];

    memtype_resolver #(.ADDR_W(ADDR_W), .NUM_VAR(NUM_VAR)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_kind(cfg_kind),
        .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .req_valid(req_valid),
        .req_ready(req_ready), .req_start(req_start), .req_end(req_end),
        .rsp_done(rsp_done), .rsp_type(rsp_type)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cfg_write(input int kind, input int idx, input logic [ADDR_W-1:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_kind = 3'(kind); cfg_idx = 7'(idx); cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Driver: issue one lookup and push its expected result.
    task automatic lookup(input logic [ADDR_W-1:0] s, input logic [ADDR_W-1:0] e,
                          input logic [7:0] exp, input string tag);
        wait (exp_q.size() == 0);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_start = s; req_end = e;
        @(posedge clk);
        #1;
        exp_q.push_back(exp); tag_q.push_back(tag); acc_q.push_back(cyc);
        req_valid = 1'b0;
        @(negedge clk);
        check("R11 ready low while busy", req_ready, 0);
        wait (exp_q.size() == 0);
    endtask

    // Monitor: compare every done pulse with the head of the scoreboard.
    always @(negedge clk) begin
        if (rst_n && rsp_done) begin
            if (exp_q.size() == 0) begin
                check("R11 unexpected done", 1, 0);
            end else begin
                check(tag_q[0], rsp_type, exp_q[0]);
                check("R11 latency", cyc - acc_q[0], NUM_VAR + 1);
                void'(exp_q.pop_front()); void'(tag_q.pop_front()); void'(acc_q.pop_front());
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 ready after reset", req_ready, 1);
        check("R1 done after reset", rsp_done, 0);
        lookup(40'h0, 40'hFFF, 8'hFF, "R1 cleared config gives off code");

        // R2 R4: fixed table entries i get 0x40+i; control: default WB, fixed enabled
        for (int i = 0; i < 88; i++) cfg_write(1, i, ADDR_W'(40'h40 + i));
        cfg_write(0, 0, 40'h406);
        lookup(40'h00000, 40'h00FFF, 8'h40, "R4 64K region entry 0");
        lookup(40'h7FFFF, 40'h7FFFF, 8'h47, "R4 64K region entry 7");
        lookup(40'h12345, 40'h3FFFFFF, 8'h41, "R4 start alone selects");
        lookup(40'h80000, 40'h80FFF, 8'h48, "R4 16K region entry 8");
        lookup(40'hBC000, 40'hBCFFF, 8'h57, "R4 16K region entry 23");
        lookup(40'hC0000, 40'hC0FFF, 8'h58, "R4 4K region entry 24");
        lookup(40'hD5000, 40'hD5FFF, 8'h6D, "R4 4K region entry 45");
        lookup(40'hFF000, 40'hFFFFF, 8'h97, "R4 4K region entry 87");
        lookup(40'h100000, 40'h100FFF, 8'h06, "R5 above 1M var disabled gives default");

        // R3: both enables clear
        cfg_write(0, 0, 40'h006);
        lookup(40'h1000, 40'h1FFF, 8'hFF, "R3 both enables clear");

        // Variable regions (R6 junk low bits in r0 base and mask)
        cfg_write(2, 0, 40'h00_0020_0F06); cfg_write(3, 0, 40'hFF_FFE0_0FFF);
        cfg_write(2, 1, 40'h00_0020_0004); cfg_write(3, 1, 40'hFF_FFF8_0800);
        cfg_write(2, 2, 40'h00_0080_0001); cfg_write(3, 2, 40'hFF_FFF0_0800);
        cfg_write(2, 3, 40'h00_0080_0005); cfg_write(3, 3, 40'hFF_FFF0_0800);
        cfg_write(2, 4, 40'h00_00A0_0000); cfg_write(3, 4, 40'hFF_FFF0_0800);
        cfg_write(2, 5, 40'h00_00A0_0006); cfg_write(3, 5, 40'hFF_FFF0_0800);
        cfg_write(2, 6, 40'h00_00C0_0000); cfg_write(3, 6, 40'hFF_FFF0_0000);
        cfg_write(2, 7, 40'h00_0080_0001); cfg_write(3, 7, 40'hFF_FFF8_0800);
        cfg_write(0, 0, 40'hC01);

        lookup(40'h280000, 40'h280FFF, 8'h06, "R6 low 12 bits ignored single match");
        lookup(40'h200000, 40'h200FFF, 8'h04, "R8 WB with WT gives WT");
        lookup(40'h800000, 40'h800FFF, 8'h00, "R8 WC with WP gives UC");
        lookup(40'hA00000, 40'hA00FFF, 8'h00, "R8 UC wins over WB");
        lookup(40'h300000, 40'h400FFF, 8'hFE, "R7 straddle gives FE");
        lookup(40'h500000, 40'h500FFF, 8'h01, "R9 no match gives default");
        lookup(40'h800000, 40'h8FFFFF, 8'h00, "R12 UC conflict before later straddle");
        lookup(40'h200000, 40'h2FFFFF, 8'hFE, "R12 straddle after earlier match");
        lookup(40'hC00000, 40'hC00FFF, 8'h01, "R6 invalid region ignored");
        lookup(40'h01000, 40'h01FFF, 8'h40, "R4 fixed wins below 1M");

        cfg_write(3, 6, 40'hFF_FFF0_0800);
        lookup(40'hC00000, 40'hC00FFF, 8'h00, "R6 valid bit enables region");

        cfg_write(0, 0, 40'h801);
        lookup(40'h01000, 40'h01FFF, 8'h01, "R5 fixed disabled falls to variable path");

        // R10: limit 0x1_2345_6789 rounds to 0x1_2300_0000
        cfg_write(4, 0, 40'h01_2345_6789);
        lookup(40'h01_0000_0000, 40'h01_22FF_FFFF, 8'h06, "R10 window gives WB");
        lookup(40'h01_0000_0000, 40'h01_2300_0000, 8'h01, "R10 low bits forced zero");
        lookup(40'h00_FFFF_F000, 40'h01_0000_0FFF, 8'h01, "R10 start below 4G");

        repeat (4) @(negedge clk);
        check("R11 no stray done", exp_q.size(), 0);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog R11 actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule